// File: doc/BRIEF.md
# Auto-Incrementing RGB Palette Look-Up Table

This block keeps three small colour palettes (red, green and blue), each with 16 entries of 4 bits. A CPU reaches them through two registers. The index register sets the walk mode and the starting entry. The data port reads or writes one palette entry per access. A colour pointer selects the palette that the data port reaches. In the sequential mode the pointer cycles through the three colours, and the entry number steps up after each blue access, so a host can stream a whole palette as R, G, B triples. In the three fixed modes the pointer stays on one colour, and every access steps the entry number.

On the display side, a 4-bit pixel value indexes all three palettes together. The block returns three colour weights and a gray weight, and the gray weight is taken from the green palette. In direct-colour mode the palettes are skipped, and the weights are sliced straight from a 16-bit 5:6:5 pixel word.

The pointer is a three-state machine with the states PTR_RED, PTR_GRN and PTR_BLU. It has three transitions:
- T_LOAD: an index-register write places the pointer on RED for modes 00 and 01, on GRN for mode 10, and on BLU for mode 11.
- T_STEP: in mode 00, a data access moves the pointer RED→GRN→BLU→RED. The move from BLU to RED also steps the entry number.
- T_HOLD: in a fixed mode a data access keeps the state and steps the entry number. With no access, nothing changes.

Top module: `pal_lut_top`

## Requirements
- R1: After reset the pointer is red, the entry number is 0, the mode is 00, every palette entry is 0, and `cpu_rdata` is 0.
- R2: A write with `cpu_sel`=0 loads the mode from `cpu_wdata[5:4]` and the entry number from `cpu_wdata[3:0]`. A read with `cpu_sel`=0 returns {2'b00, mode, entry} and moves neither the pointer nor the entry number.
- R3: In mode 00, an index write places the pointer on red, even in the middle of a walk. Each data access then moves it red→green→blue→red.
- R4: In mode 00 the entry number increases by 1 only after a blue access, so the access order is R[n], G[n], B[n], R[n+1].
- R5: Modes 01, 10 and 11 hold the pointer on red, green and blue respectively. Every data access increases the entry number by 1.
- R6: Data reads and data writes advance the pointer and the entry number in the same way.
- R7: The entry number wraps from 15 to 0.
- R8: A data write stores `cpu_wdata[3:0]` and ignores bits 7:4. A data read returns {4'b0000, entry} on `cpu_rdata` in the cycle after the access, and the value holds until the next read.
- R9: One clock after `pix_index` is applied with `direct_mode`=0, `pix_red`, `pix_grn` and `pix_blu` show the three palette entries at that index, and `pix_gray` equals the green entry.
- R10: With `direct_mode`=1, one clock later `pix_red`=`pix_direct[15:12]`, `pix_grn`=`pix_direct[10:7]`, `pix_blu`=`pix_direct[4:1]`, and `pix_gray`=`pix_direct[10:7]`.
- R11: When a data write hits the entry that the display is looking up in the same cycle, the display output one clock later shows the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_cs | input | 1 | CPU access strobe, one access per cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_sel | input | 1 | 0 = index register, 1 = data port |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Registered CPU read data |
| pix_index | input | 4 | Palette pixel value |
| pix_direct | input | 16 | Direct-colour 5:6:5 pixel word |
| direct_mode | input | 1 | 1 = skip the palettes |
| pix_red | output | 4 | Red weight |
| pix_grn | output | 4 | Green weight |
| pix_blu | output | 4 | Blue weight |
| pix_gray | output | 4 | Gray weight |

## Verification
Every result of this block is registered once. Read data and the effects of a data or index access appear after the rising edge that accepts the access. A display weight appears after the rising edge that follows the pixel input. The bench drives each stimulus on a falling edge and samples on the next falling edge, which is exactly one rising edge later. Pointer and entry-number movement is never observed directly. It is checked through readback values and index-register reads, which come out of the design after the same single edge.

// File: rtl/pal_pkg.sv
package pal_pkg;
    typedef enum logic [1:0] {
        PTR_RED = 2'd0,
        PTR_GRN = 2'd1,
        PTR_BLU = 2'd2
    } ptr_e;

    localparam logic [1:0] MODE_SEQ = 2'b00;
    localparam logic [1:0] MODE_RED = 2'b01;
    localparam logic [1:0] MODE_GRN = 2'b10;
    localparam logic [1:0] MODE_BLU = 2'b11;
    localparam int         N_COLOURS = 3;
endpackage

// File: rtl/pal_ptr_fsm.sv
module pal_ptr_fsm
    import pal_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr,
    input  logic          data_acc,
    input  logic [1:0]    wr_mode,
    input  logic [AW-1:0] wr_addr,
    output ptr_e          ptr,
    output logic [AW-1:0] addr,
    output logic [1:0]    mode
);
    ptr_e          ptr_q, ptr_d;
    logic [AW-1:0] addr_q, addr_d;
    logic [1:0]    mode_q, mode_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= PTR_RED;
            addr_q <= '0;
            mode_q <= MODE_SEQ;
        end else begin
            ptr_q  <= ptr_d;
            addr_q <= addr_d;
            mode_q <= mode_d;
        end
    end

    // next state: T_LOAD, T_STEP, T_HOLD
    always_comb begin
        ptr_d  = ptr_q;
        addr_d = addr_q;
        mode_d = mode_q;
        if (idx_wr) begin
            mode_d = wr_mode;
            addr_d = wr_addr;
            unique case (wr_mode)
                MODE_SEQ: ptr_d = PTR_RED;
                MODE_RED: ptr_d = PTR_RED;
                MODE_GRN: ptr_d = PTR_GRN;
                MODE_BLU: ptr_d = PTR_BLU;
            endcase
        end else if (data_acc) begin
            if (mode_q == MODE_SEQ) begin
                unique case (ptr_q)
                    PTR_RED: ptr_d = PTR_GRN;
                    PTR_GRN: ptr_d = PTR_BLU;
                    PTR_BLU: begin
                        ptr_d  = PTR_RED;
                        addr_d = addr_q + 1'b1;
                    end
                    default: ptr_d = PTR_RED;
                endcase
            end else begin
                addr_d = addr_q + 1'b1;
            end
        end
    end

    assign ptr  = ptr_q;
    assign addr = addr_q;
    assign mode = mode_q;
endmodule

// File: rtl/pal_bank.sv
module pal_bank #(
    parameter int AW = 4,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] cpu_raddr,
    output logic [DW-1:0] cpu_rdata,
    input  logic [AW-1:0] pix_raddr,
    output logic [DW-1:0] pix_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign cpu_rdata = mem[cpu_raddr];
    // a write in the same cycle wins over the stored value
    assign pix_rdata = (we && (waddr == pix_raddr)) ? wdata : mem[pix_raddr];
endmodule

// File: rtl/pal_disp.sv
module pal_disp #(
    parameter int DW = 4,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          direct_mode,
    input  logic [PW-1:0] pix_direct,
    input  logic [DW-1:0] lut_red,
    input  logic [DW-1:0] lut_grn,
    input  logic [DW-1:0] lut_blu,
    output logic [DW-1:0] out_red,
    output logic [DW-1:0] out_grn,
    output logic [DW-1:0] out_blu,
    output logic [DW-1:0] out_gray
);
    localparam int RED_MSB = PW - 1;
    localparam int GRN_MSB = PW - 6;
    localparam int BLU_MSB = PW - 12;

    logic [DW-1:0] sel_red, sel_grn, sel_blu;
    logic          unused_direct;

    assign unused_direct = ^{pix_direct[RED_MSB-DW], pix_direct[GRN_MSB-DW:BLU_MSB+1],
                             pix_direct[BLU_MSB-DW:0]};

    always_comb begin
        if (direct_mode) begin
            sel_red = pix_direct[RED_MSB -: DW];
            sel_grn = pix_direct[GRN_MSB -: DW];
            sel_blu = pix_direct[BLU_MSB -: DW];
        end else begin
            sel_red = lut_red;
            sel_grn = lut_grn;
            sel_blu = lut_blu;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_red  <= '0;
            out_grn  <= '0;
            out_blu  <= '0;
            out_gray <= '0;
        end else begin
            out_red  <= sel_red;
            out_grn  <= sel_grn;
            out_blu  <= sel_blu;
            out_gray <= sel_grn;
        end
    end
endmodule

// File: rtl/pal_lut_top.sv
module pal_lut_top
    import pal_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 4,
    parameter int CW = 8,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_cs,
    input  logic          cpu_we,
    input  logic          cpu_sel,
    input  logic [CW-1:0] cpu_wdata,
    output logic [CW-1:0] cpu_rdata,
    input  logic [AW-1:0] pix_index,
    input  logic [PW-1:0] pix_direct,
    input  logic          direct_mode,
    output logic [DW-1:0] pix_red,
    output logic [DW-1:0] pix_grn,
    output logic [DW-1:0] pix_blu,
    output logic [DW-1:0] pix_gray
);
    logic          idx_wr, data_acc, data_wr;
    ptr_e          cur_ptr;
    logic [AW-1:0] cur_addr;
    logic [1:0]    cur_mode;
    logic [DW-1:0] bank_cpu [N_COLOURS];
    logic [DW-1:0] bank_pix [N_COLOURS];
    logic [DW-1:0] cpu_entry;
    logic          unused_wdata;

    assign idx_wr   = cpu_cs && cpu_we && !cpu_sel;
    assign data_acc = cpu_cs && cpu_sel;
    assign data_wr  = data_acc && cpu_we;
    assign unused_wdata = ^cpu_wdata[CW-1:AW+2];

    pal_ptr_fsm #(.AW(AW)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .data_acc (data_acc),
        .wr_mode  (cpu_wdata[AW+1:AW]),
        .wr_addr  (cpu_wdata[AW-1:0]),
        .ptr      (cur_ptr),
        .addr     (cur_addr),
        .mode     (cur_mode)
    );

    for (genvar c = 0; c < N_COLOURS; c++) begin : g_bank
        pal_bank #(.AW(AW), .DW(DW)) bank_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (data_wr && (cur_ptr == ptr_e'(c))),
            .waddr     (cur_addr),
            .wdata     (cpu_wdata[DW-1:0]),
            .cpu_raddr (cur_addr),
            .cpu_rdata (bank_cpu[c]),
            .pix_raddr (pix_index),
            .pix_rdata (bank_pix[c])
        );
    end

    always_comb begin
        unique case (cur_ptr)
            PTR_GRN: cpu_entry = bank_cpu[1];
            PTR_BLU: cpu_entry = bank_cpu[2];
            default: cpu_entry = bank_cpu[0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rdata <= '0;
        end else if (cpu_cs && !cpu_we) begin
            cpu_rdata <= cpu_sel ? CW'(cpu_entry) : CW'({cur_mode, cur_addr});
        end
    end

    pal_disp #(.DW(DW), .PW(PW)) disp_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .direct_mode (direct_mode),
        .pix_direct  (pix_direct),
        .lut_red     (bank_pix[0]),
        .lut_grn     (bank_pix[1]),
        .lut_blu     (bank_pix[2]),
        .out_red     (pix_red),
        .out_grn     (pix_grn),
        .out_blu     (pix_blu),
        .out_gray    (pix_gray)
    );
endmodule

// File: rtl/pal_lut_chk.sv
module pal_lut_chk #(
    parameter int AW = 4,
    parameter int DW = 4,
    parameter int CW = 8,
    parameter int PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          idx_wr,
    input logic          data_acc,
    input logic [CW-1:0] cpu_wdata,
    input logic [CW-1:0] cpu_rdata,
    input logic [1:0]    mode,
    input logic [AW-1:0] addr,
    input logic [1:0]    ptr,
    input logic          direct_mode,
    input logic [PW-1:0] pix_direct,
    input logic [DW-1:0] pix_red
);
    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (mode == $past(cpu_wdata[AW+1:AW])) && (addr == $past(cpu_wdata[AW-1:0]))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_wr && !data_acc) |=> $stable(addr) && $stable(ptr) && $stable(mode)); // R2
    AST_SEQ_LOAD_RED: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && cpu_wdata[AW+1:AW] == 2'b00) |=> (ptr == 2'd0)); // R3
    AST_PTR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ptr != 2'd3); // R3
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && mode == 2'b00 && ptr != 2'd2) |=> (ptr == $past(ptr) + 2'd1) && $stable(addr)); // R4
    AST_SEQ_BLUE_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && mode == 2'b00 && ptr == 2'd2) |=> (ptr == 2'd0) && (addr == AW'($past(addr) + 1'b1))); // R7
    AST_FIXED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && mode != 2'b00) |=> (ptr == $past(mode) - 2'd1) && (addr == AW'($past(addr) + 1'b1))); // R5
    AST_RDATA_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[CW-1:AW+2] == '0); // R8
    AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        direct_mode |=> pix_red == $past(pix_direct[PW-1 -: DW])); // R10
endmodule

bind pal_lut_top pal_lut_chk #(.AW(AW), .DW(DW), .CW(CW), .PW(PW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .idx_wr      (idx_wr),
    .data_acc    (data_acc),
    .cpu_wdata   (cpu_wdata),
    .cpu_rdata   (cpu_rdata),
    .mode        (cur_mode),
    .addr        (cur_addr),
    .ptr         (cur_ptr),
    .direct_mode (direct_mode),
    .pix_direct  (pix_direct),
    .pix_red     (pix_red)
);

// File: tb/pal_lut_top_tb_top.sv
module pal_lut_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_cs = 1'b0, cpu_we = 1'b0, cpu_sel = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [3:0]  pix_index = '0;
    logic [15:0] pix_direct = '0;
    logic        direct_mode = 1'b0;
    logic [3:0]  pix_red, pix_grn, pix_blu, pix_gray;

    int checks = 0;
    int failures = 0;
    logic [3:0] mdl [3][16];
    logic [7:0] rd;

    always #5 clk = ~clk;

    pal_lut_top dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_cs(cpu_cs), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pix_index(pix_index),
        .pix_direct(pix_direct), .direct_mode(direct_mode), .pix_red(pix_red),
        .pix_grn(pix_grn), .pix_blu(pix_blu), .pix_gray(pix_gray)
    );

    function automatic logic [3:0] pat(int c, int n);
        return 4'((5 * n + 3 * c + 7) & 15);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_op(input logic sel, input logic we, input logic [7:0] wd, output logic [7:0] r);
        @(negedge clk);
        cpu_cs = 1'b1; cpu_sel = sel; cpu_we = we; cpu_wdata = wd;
        @(negedge clk);
        r = cpu_rdata;
        cpu_cs = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic pix_check(input string req, input logic [3:0] idx, input logic [3:0] er,
                             input logic [3:0] eg, input logic [3:0] eb);
        @(negedge clk);
        pix_index = idx;
        @(negedge clk);
        check({req, " red"}, 8'(pix_red), 8'(er));
        check({req, " grn"}, 8'(pix_grn), 8'(eg));
        check({req, " blu"}, 8'(pix_blu), 8'(eb));
        check({req, " gray"}, 8'(pix_gray), 8'(eg));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check("R1 rdata", cpu_rdata, 8'h00);
        check("R1 pix_gray", 8'(pix_gray), 8'h00);
        cpu_op(1'b0, 1'b0, 8'h00, rd);
        check("R1 index reg", rd, 8'h00);
        cpu_op(1'b1, 1'b0, 8'h00, rd);
        check("R1 entry cleared", rd, 8'h00);
        cpu_op(1'b0, 1'b0, 8'h00, rd);
        check("R2 read no advance", rd, 8'h00);

        // R3 R4 R6 sequential fill of all entries
        cpu_op(1'b0, 1'b1, 8'h00, rd);
        for (int n = 0; n < 16; n++)
            for (int c = 0; c < 3; c++) begin
                mdl[c][n] = pat(c, n);
                cpu_op(1'b1, 1'b1, {4'hA, pat(c, n)}, rd);
            end
        cpu_op(1'b0, 1'b0, 8'h00, rd);
        check("R7 seq wrap to 0", rd, 8'h00);

        // R5 R8 fixed-mode readback of every colour
        for (int c = 1; c <= 3; c++) begin
            cpu_op(1'b0, 1'b1, 8'(c << 4), rd);
            for (int n = 0; n < 16; n++) begin
                cpu_op(1'b1, 1'b0, 8'h00, rd);
                check("R5 fixed read", rd, {4'h0, mdl[c-1][n]});
            end
            cpu_op(1'b0, 1'b0, 8'h00, rd);
            check("R7 fixed wrap", rd, 8'(c << 4));
        end

        // R5 fixed-mode writes into green, checked by a sequential read (R6)
        cpu_op(1'b0, 1'b1, 8'h2C, rd);
        cpu_op(1'b1, 1'b1, 8'h09, rd); mdl[1][12] = 4'h9;
        cpu_op(1'b1, 1'b1, 8'h03, rd); mdl[1][13] = 4'h3;
        cpu_op(1'b0, 1'b0, 8'h00, rd);
        check("R2 index readback", rd, 8'h2E);
        cpu_op(1'b0, 1'b1, 8'h0C, rd);
        cpu_op(1'b1, 1'b0, 8'h00, rd); check("R4 R12", rd, {4'h0, mdl[0][12]});
        cpu_op(1'b1, 1'b0, 8'h00, rd); check("R4 G12", rd, {4'h0, mdl[1][12]});
        cpu_op(1'b1, 1'b0, 8'h00, rd); check("R4 B12", rd, {4'h0, mdl[2][12]});
        cpu_op(1'b1, 1'b0, 8'h00, rd); check("R4 R13", rd, {4'h0, mdl[0][13]});
        cpu_op(1'b1, 1'b0, 8'h00, rd); check("R6 G13", rd, {4'h0, mdl[1][13]});
        cpu_op(1'b0, 1'b0, 8'h00, rd);
        check("R4 addr after G13", rd, 8'h0D);

        // R3 index write restarts the walk on red
        cpu_op(1'b0, 1'b1, 8'h0E, rd);
        cpu_op(1'b1, 1'b1, 8'h06, rd); mdl[0][14] = 4'h6;
        cpu_op(1'b0, 1'b1, 8'h0E, rd);
        cpu_op(1'b1, 1'b0, 8'h00, rd); check("R3 restart red", rd, 8'h06);
        cpu_op(1'b1, 1'b0, 8'h00, rd); check("R3 then green", rd, {4'h0, mdl[1][14]});

        // R7 sequential wrap from entry 15
        cpu_op(1'b0, 1'b1, 8'h0F, rd);
        for (int c = 0; c < 3; c++) begin
            cpu_op(1'b1, 1'b0, 8'h00, rd);
            check("R3 entry 15 walk", rd, {4'h0, mdl[c][15]});
        end
        cpu_op(1'b0, 1'b0, 8'h00, rd);
        check("R7 wrap 15 to 0", rd, 8'h00);

        // R9 display sweep of every index
        for (int i = 0; i < 16; i++)
            pix_check("R9 lookup", 4'(i), mdl[0][i], mdl[1][i], mdl[2][i]);

        // R10 direct-colour bypass
        @(negedge clk);
        direct_mode = 1'b1;
        for (int k = 0; k < 8; k++) begin
            logic [15:0] w;
            w = 16'(k * 16'h2F1D) ^ 16'hA5C3;
            pix_direct = w;
            @(negedge clk);
            check("R10 red", 8'(pix_red), 8'(w[15:12]));
            check("R10 grn", 8'(pix_grn), 8'(w[10:7]));
            check("R10 blu", 8'(pix_blu), 8'(w[4:1]));
            check("R10 gray", 8'(pix_gray), 8'(w[10:7]));
        end
        direct_mode = 1'b0;

        // R11 same-cycle write and lookup; R8 upper data bits ignored
        cpu_op(1'b0, 1'b1, 8'h25, rd);
        @(negedge clk);
        pix_index = 4'd5;
        cpu_cs = 1'b1; cpu_sel = 1'b1; cpu_we = 1'b1; cpu_wdata = 8'hFB;
        @(negedge clk);
        cpu_cs = 1'b0; cpu_we = 1'b0;
        mdl[1][5] = 4'hB;
        check("R11 write wins", 8'(pix_grn), 8'h0B);
        check("R11 gray", 8'(pix_gray), 8'h0B);
        cpu_op(1'b0, 1'b1, 8'h25, rd);
        cpu_op(1'b1, 1'b0, 8'h00, rd);
        check("R8 upper bits ignored", rd, 8'h0B);
        check("R8 rdata holds", cpu_rdata, 8'h0B);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule